// File: doc/BRIEF.md
# Scheduled Euler-Step Loop Engine

This block is a multicycle datapath with its own controller that iterates a small integer differential-equation step. After a start pulse it takes five operands from two input ports over three cycles: the position `x`, the step `dx`, the state `u`, the bound `a` and the accumulator `y`. While `x < a` it repeats one update of `u`, `y` and `x`, then presents the final `y` on its output with a one-cycle completion pulse.

All loop arithmetic runs on a shared pool of units: two multipliers, one adder/subtractor and one less-than comparator. Operand multiplexers feed these units, and the controller sets their selects and the register enables in each state. One iteration takes a fixed four-step body plus one branch state. All values are two's-complement and wrap at the data width.

Top module: `euler_loop_engine`

## Requirements
- R1: When `start_i` is sampled high in the idle state, the next three rising edges load the operands. The first edge takes `x` from `port1_i` and `u` from `port2_i`. The second takes `dx` from the low DXW bits of `port1_i` and `a` from `port2_i`. The third takes `y` from `port2_i`. Port values at any other time have no effect on the result.
- R2: Each iteration computes t1=u*dx, t2=3*x, t3=3*y, t4=t1*t2 and t5=t3*dx. It then sets u=u-t4-t5, y=y+t1 and x=x+dx, with `dx` sign-extended and every result taken modulo 2^DW.
- R3: The loop runs while x < a as a signed DW-bit comparison. If x >= a at the first test, including x == a, the loaded `y` is output unchanged.
- R4: For N iterations, `done_o` rises with the (5+5N)-th rising edge after the edge that samples `start_i`.
- R5: `done_o` is high for exactly one cycle. `y_o` carries the final y (DW bits) from that cycle on and holds until the next completion.
- R6: A `start_i` pulse outside the idle state is ignored: the result and the completion time of the run in progress do not change.
- R7: Synchronous active-high reset drives `done_o` and `y_o` to zero and returns the controller to idle.
- R8: Operations in the same control step read the register values from before that step. For example, 3*x in the first step uses the x from before the x+dx update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| port1_i | input | DW | Operand port 1 (x, then dx) |
| port2_i | input | DW | Operand port 2 (u, then a, then y) |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | DW | Final y, registered |

## Verification
Results are due at fixed edge counts. The three operand loads fall on the first three edges after start is sampled. Completion falls on edge 5+5N, where N is the iteration count that the bench's own wrap-around model of the loop predicts. The bench drives and samples on falling edges and counts rising edges from the start edge, so it checks both the exact completion cycle and the output value in that cycle. It then checks that `done_o` is low one cycle later and that `y_o` still holds three cycles after that.

// File: rtl/euler_pkg.sv
package euler_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LD1, ST_LD2, ST_LD3, ST_COND,
    ST_S1, ST_S2, ST_S3, ST_S4, ST_OUT, ST_FIN
  } state_e;

  // multiplier 1, operand A: 0 product reg 1, 1 u, 2 constant
  localparam logic [1:0] M1_P1 = 2'd0;
  localparam logic [1:0] M1_U  = 2'd1;
  localparam logic [1:0] M1_K  = 2'd2;
  // multiplier 1, operand B: 0 dx, 1 y
  localparam logic M2_DX = 1'b0;
  localparam logic M2_Y  = 1'b1;
  // multiplier 2, operand A: 0 product reg 1, 1 constant
  localparam logic M3_P1 = 1'b0;
  localparam logic M3_K  = 1'b1;
  // multiplier 2, operand B: 0 product reg 2, 1 x
  localparam logic M4_P2 = 1'b0;
  localparam logic M4_X  = 1'b1;
  // adder operand A: 0 product reg 2, 1 x, 2 u, 3 y
  localparam logic [1:0] M5_P2 = 2'd0;
  localparam logic [1:0] M5_X  = 2'd1;
  localparam logic [1:0] M5_U  = 2'd2;
  localparam logic [1:0] M5_Y  = 2'd3;
  // adder operand B: 0 product reg 1, 1 product reg 2, 2 dx
  localparam logic [1:0] M6_P1 = 2'd0;
  localparam logic [1:0] M6_P2 = 2'd1;
  localparam logic [1:0] M6_DX = 2'd2;

  typedef struct packed {
    logic [1:0] m1;
    logic       m2;
    logic       m3;
    logic       m4;
    logic [1:0] m5;
    logic [1:0] m6;
    logic       p2_from_add;
    logic       sub;
    logic       from_port;
    logic       en_p1;
    logic       en_p2;
    logic       en_x;
    logic       en_u;
    logic       en_a;
    logic       en_y;
    logic       en_k;
    logic       en_dx;
    logic       en_c;
    logic       out_en;
  } ctl_t;

endpackage

// File: rtl/euler_opmux.sv
module euler_opmux #(
  parameter int N = 2,
  parameter int W = 32,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] din,
  input  logic [SW-1:0]       sel,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(sel) == i) dout = din[i];
    end
  end
endmodule

// File: rtl/euler_fu.sv
module euler_fu #(
  parameter int  W      = 32,
  parameter bit  IS_MUL = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] r
);
  generate
    if (IS_MUL) begin : g_mul
      logic [2*W-1:0] full;
      assign full = a * b;
      assign r    = full[W-1:0];
      logic unused_sub;
      assign unused_sub = sub ^ (^full[2*W-1:W]);
    end else begin : g_add
      assign r = sub ? (a - b) : (a + b);
    end
  endgenerate
endmodule

// File: rtl/euler_ctrl.sv
module euler_ctrl
  import euler_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cond_i,
  output ctl_t ctl_o,
  output logic done_o
);
  state_e state_q, state_d;
  logic   done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LD1;
      ST_LD1:  state_d = ST_LD2;
      ST_LD2:  state_d = ST_LD3;
      ST_LD3:  state_d = ST_COND;
      ST_COND: state_d = cond_i ? ST_S1 : ST_OUT;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ST_S4;
      ST_S4:   state_d = ST_COND;
      ST_OUT:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_OUT);
    end
  end

  // control word per state
  always_comb begin
    ctl_o = '0;
    case (state_q)
      ST_LD1: begin
        ctl_o.from_port = 1'b1;
        ctl_o.en_x = 1'b1;
        ctl_o.en_u = 1'b1;
        ctl_o.en_k = 1'b1;
      end
      ST_LD2: begin
        ctl_o.en_dx = 1'b1;
        ctl_o.en_a  = 1'b1;
      end
      ST_LD3: begin
        ctl_o.from_port = 1'b1;
        ctl_o.en_y = 1'b1;
        ctl_o.en_c = 1'b1;
      end
      ST_S1: begin // u*dx, 3*x, x+dx
        ctl_o.m1 = M1_U;  ctl_o.m2 = M2_DX; ctl_o.en_p1 = 1'b1;
        ctl_o.m3 = M3_K;  ctl_o.m4 = M4_X;  ctl_o.en_p2 = 1'b1;
        ctl_o.m5 = M5_X;  ctl_o.m6 = M6_DX; ctl_o.en_x  = 1'b1;
      end
      ST_S2: begin // 3*y, t1*t2, y+t1
        ctl_o.m1 = M1_K;  ctl_o.m2 = M2_Y;  ctl_o.en_p1 = 1'b1;
        ctl_o.m3 = M3_P1; ctl_o.m4 = M4_P2; ctl_o.en_p2 = 1'b1;
        ctl_o.m5 = M5_Y;  ctl_o.m6 = M6_P1; ctl_o.en_y  = 1'b1;
      end
      ST_S3: begin // t3*dx, u-t4
        ctl_o.m1 = M1_P1; ctl_o.m2 = M2_DX; ctl_o.en_p1 = 1'b1;
        ctl_o.m5 = M5_U;  ctl_o.m6 = M6_P2; ctl_o.sub = 1'b1;
        ctl_o.p2_from_add = 1'b1; ctl_o.en_p2 = 1'b1;
      end
      ST_S4: begin // t6-t5, next test
        ctl_o.m5 = M5_P2; ctl_o.m6 = M6_P1; ctl_o.sub = 1'b1;
        ctl_o.en_u = 1'b1;
        ctl_o.en_c = 1'b1;
      end
      ST_OUT: ctl_o.out_en = 1'b1;
      default: ;
    endcase
  end

  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R5

  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q != ST_LD1)); // R6

  AST_BODY_SEQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_S1) |=> (state_q == ST_S2)); // R4

endmodule

// File: rtl/euler_datapath.sv
module euler_datapath
  import euler_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DXW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] p1_i,
  input  logic [DW-1:0] p2_i,
  output logic          cond_o,
  output logic [DW-1:0] y_o
);
  localparam int PW = 2 * DW;
  localparam int KW = 2;
  localparam logic [KW-1:0] K3 = KW'(3);

  logic [PW-1:0]  p1_q, p2_q;
  logic [DW-1:0]  x_q, u_q, a_q, y_q, yout_q;
  logic [DXW-1:0] dx_q;
  logic [KW-1:0]  k_q;
  logic           c_q;

  logic [PW-1:0] x_w, u_w, y_w, dx_w, k_w;
  assign x_w  = {{(PW-DW){x_q[DW-1]}}, x_q};
  assign u_w  = {{(PW-DW){u_q[DW-1]}}, u_q};
  assign y_w  = {{(PW-DW){y_q[DW-1]}}, y_q};
  assign dx_w = {{(PW-DXW){dx_q[DXW-1]}}, dx_q};
  assign k_w  = PW'(k_q);

  logic [PW-1:0] m1_o, m2_o, m3_o, m4_o, m5_o, m6_o;
  logic [PW-1:0] mul1_r, mul2_r, add_r;

  euler_opmux #(.N(3), .W(PW)) u_m1 (.din({k_w, u_w, p1_q}),       .sel(ctl.m1), .dout(m1_o));
  euler_opmux #(.N(2), .W(PW)) u_m2 (.din({y_w, dx_w}),            .sel(ctl.m2), .dout(m2_o));
  euler_opmux #(.N(2), .W(PW)) u_m3 (.din({k_w, p1_q}),            .sel(ctl.m3), .dout(m3_o));
  euler_opmux #(.N(2), .W(PW)) u_m4 (.din({x_w, p2_q}),            .sel(ctl.m4), .dout(m4_o));
  euler_opmux #(.N(4), .W(PW)) u_m5 (.din({y_w, u_w, x_w, p2_q}),  .sel(ctl.m5), .dout(m5_o));
  euler_opmux #(.N(3), .W(PW)) u_m6 (.din({dx_w, p2_q, p1_q}),     .sel(ctl.m6), .dout(m6_o));

  euler_fu #(.W(PW), .IS_MUL(1'b1)) u_mul1 (.a(m1_o), .b(m2_o), .sub(1'b0),    .r(mul1_r));
  euler_fu #(.W(PW), .IS_MUL(1'b1)) u_mul2 (.a(m3_o), .b(m4_o), .sub(1'b0),    .r(mul2_r));
  euler_fu #(.W(PW), .IS_MUL(1'b0)) u_add  (.a(m5_o), .b(m6_o), .sub(ctl.sub), .r(add_r));

  logic cmp_lt;
  assign cmp_lt = $signed(x_q) < $signed(a_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q   <= '0;
      p2_q   <= '0;
      x_q    <= '0;
      u_q    <= '0;
      a_q    <= '0;
      y_q    <= '0;
      dx_q   <= '0;
      k_q    <= '0;
      c_q    <= 1'b0;
      yout_q <= '0;
    end else begin
      if (ctl.en_p1)  p1_q   <= mul1_r;
      if (ctl.en_p2)  p2_q   <= ctl.p2_from_add ? add_r : mul2_r;
      if (ctl.en_x)   x_q    <= ctl.from_port ? p1_i : add_r[DW-1:0];
      if (ctl.en_u)   u_q    <= ctl.from_port ? p2_i : add_r[DW-1:0];
      if (ctl.en_y)   y_q    <= ctl.from_port ? p2_i : add_r[DW-1:0];
      if (ctl.en_a)   a_q    <= p2_i;
      if (ctl.en_dx)  dx_q   <= p1_i[DXW-1:0];
      if (ctl.en_k)   k_q    <= K3;
      if (ctl.en_c)   c_q    <= cmp_lt;
      if (ctl.out_en) yout_q <= y_q;
    end
  end

  assign cond_o = c_q;
  assign y_o    = yout_q;

  AST_BODY_NEEDS_TRUE: assert property (@(posedge clk) disable iff (rst)
    (ctl.en_x && !ctl.from_port) |-> c_q); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.out_en |=> $stable(yout_q)); // R5

endmodule

// File: rtl/euler_loop_engine.sv
module euler_loop_engine
  import euler_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DXW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] port1_i,
  input  logic [DW-1:0] port2_i,
  output logic          done_o,
  output logic [DW-1:0] y_o
);
  ctl_t ctl;
  logic cond;

  euler_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cond_i  (cond),
    .ctl_o   (ctl),
    .done_o  (done_o)
  );

  euler_datapath #(.DW(DW), .DXW(DXW)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .p1_i   (port1_i),
    .p2_i   (port2_i),
    .cond_o (cond),
    .y_o    (y_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done_o && (y_o == '0))); // R7

endmodule

// File: tb/euler_loop_engine_tb.sv
`timescale 1ns/1ps
module euler_loop_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] p1 = '0, p2 = '0;
  logic        done;
  logic [15:0] yo;
  int unsigned cyc = 0;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  euler_loop_engine #(.DW(16), .DXW(8)) dut_i (
    .clk(clk), .rst(rst), .start_i(start),
    .port1_i(p1), .port2_i(p2), .done_o(done), .y_o(yo)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // independent wrap-around model of the loop
  task automatic model(input logic [15:0] x0, input logic [7:0] dx0,
                       input logic [15:0] u0, input logic [15:0] a0,
                       input logic [15:0] y0,
                       output logic [15:0] yres, output int n);
    logic signed [15:0] x, dx, u, a, y, t1, t2, t3, t4, t5;
    x = x0; dx = {{8{dx0[7]}}, dx0}; u = u0; a = a0; y = y0;
    n = 0;
    while (x < a && n < 1000) begin
      t1 = u * dx;
      t2 = 16'sd3 * x;
      t3 = 16'sd3 * y;
      t4 = t1 * t2;
      t5 = t3 * dx;
      u  = u - t4 - t5;
      y  = y + t1;
      x  = x + dx;
      n++;
    end
    yres = y;
  endtask

  task automatic run_case(input string tag, input logic [15:0] x, input logic [7:0] dx,
                          input logic [15:0] u, input logic [15:0] a,
                          input logic [15:0] y, input int poke);
    logic [15:0] ye, yg;
    int n, lat;
    int unsigned t0;
    bit seen;
    model(x, dx, u, a, y, ye, n);
    @(negedge clk); start = 1'b1; p1 = 16'h1357; p2 = 16'h2468; t0 = cyc;
    @(negedge clk); start = 1'b0; p1 = x; p2 = u;
    @(negedge clk); p1 = {8'hA5, dx}; p2 = a;
    @(negedge clk); p1 = 16'h5A5A; p2 = y;
    @(negedge clk); p1 = 16'hBEEF; p2 = 16'hCAFE; // R1: late port values ignored
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) seen = 1'b1;
      else begin
        if (poke > 0 && i == poke) start = 1'b1; // R6
        @(negedge clk);
        start = 1'b0;
      end
    end
    lat = int'(cyc - t0);
    chk(seen, {tag, " R4 done seen"}, seen, 1);
    chk(lat == 6 + 5 * n, {tag, " R4 latency edges"}, lat, 6 + 5 * n);
    chk(yo == ye, {tag, " R2 R1 y result"}, yo, ye);
    yg = yo;
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk(yo == yg, {tag, " R5 y holds"}, yo, yg);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(yo == 16'h0, "R7 reset y", yo, 0);
  endtask

  task automatic t_skip_greater;  // R3
    run_case("skip_gt R3", 16'd20, 8'd1, 16'd9, 16'd10, 16'd777, 0);
    chk(yo == 16'd777, "R3 y unchanged x>a", yo, 777);
  endtask

  task automatic t_skip_equal;    // R3
    run_case("skip_eq R3", 16'd7, 8'd2, 16'd4, 16'd7, 16'hFFF0, 0);
    chk(yo == 16'hFFF0, "R3 y unchanged x==a", yo, 16'hFFF0);
  endtask

  task automatic t_single;        // R2 R8
    run_case("single R8", 16'd0, 8'd5, 16'd3, 16'd3, 16'd10, 0);
  endtask

  task automatic t_multi;         // R2 R8
    run_case("multi R2", 16'd0, 8'd1, 16'd2, 16'd6, 16'd1, 0);
  endtask

  task automatic t_negative;      // R2 R3
    run_case("negative R3", 16'hFFF6, 8'd3, 16'hFFF9, 16'd2, 16'd100, 0);
  endtask

  task automatic t_busy_start;    // R6
    run_case("busy_start R6", 16'd1, 8'd2, 16'd5, 16'd9, 16'd11, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_skip_greater();
    t_skip_equal();
    t_single();
    t_multi();
    t_negative();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule